// File: doc/BRIEF.md
# Sparse-Tap Reloadable Multipath Channel Filter

This block models one time-varying single-antenna propagation path set as a tapped delay line in which only a handful of echoes are non-zero. Real-valued signed input samples enter a delay line whose length equals the largest excess delay to be modelled. A small, fixed number of path units each pick one delay-line position chosen at run time and scale it by a signed gain. All path products are summed at full precision. The output is the sum over every path k of gain_k times the input sample delayed by delay_k samples.

Path delays and gains are written one path at a time into a shadow bank while the filter keeps running. A single swap pulse moves the whole shadow bank into the active bank in one clock edge, so the channel can be refreshed periodically to follow fading without any output sample mixing an old and a new profile. The wide, untruncated sum goes to a downstream word-reduction stage. Four instances and two adders make a 2x2 link: receive output 1 adds the h11 filter on input 1 to the h21 filter on input 2, and receive output 2 adds h12 on input 1 to h22 on input 2.

Default parameters give a 14-sample line with 9 paths. The same RTL also covers a 180-sample line with 49 paths.

Top module: `sparse_fir_channel`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_sum` is 0. All path gains and delays reset to 0 in both banks, and the delay line resets to zeros.
- R2: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` high, three clock edges later. No other cycle raises `out_valid`.
- R3: Each output equals the sum over paths k of coef_k * x(n - delay_k). Here x(n) is the sample accepted with the strobe, and x(n-j) is the j-th earlier accepted sample (zero before any were accepted). The sum is exact, with no overflow, even when every path multiplies full-scale values (-8192 * -32768 on all 9 paths gives 2415919104).
- R4: A path delay of 0 selects the sample accepted in the same strobe.
- R5: Writes (`cfg_we` high, path number `cfg_sel`, values `cfg_delay` and `cfg_coef`) land only in the shadow bank. They do not change any output until a swap.
- R6: A one-cycle `cfg_swap` copies all shadow paths into the active bank at that edge. Samples accepted after the swap use the new profile on every path.
- R7: A path whose delay is `LINE_LEN` or more (14 or 15 by default) contributes 0 to the sum.
- R8: A write with `cfg_sel` of `PATHS` or more (9 to 15 by default) is ignored and changes no path.
- R9: While `out_valid` is low, `out_sum` keeps the value of the last valid output.
- R10: The delay line advances only on cycles with `in_valid` high. Idle cycles between samples do not count as delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 14 | Signed input sample |
| cfg_we | input | 1 | Shadow-bank path write enable |
| cfg_sel | input | 4 | Path number to write |
| cfg_delay | input | 4 | Path delay in samples |
| cfg_coef | input | 16 | Signed path gain |
| cfg_swap | input | 1 | Copy the shadow bank into the active bank |
| out_valid | output | 1 | Output strobe, three edges after `in_valid` |
| out_sum | output | 34 | Signed full-precision path sum |

## Verification
A sample driven just after edge E is accepted at E+1. Its products register at E+2 and its sum at E+3. So `out_valid` and the matching `out_sum` are first visible at the falling edge after E+3. The bench keeps a three-deep history of `in_valid` taken at falling edges and requires `out_valid` to equal the entry from three falling edges earlier. It pops an expected value, computed from its own delay-line and bank model, only on those strobes. On every falling edge with `out_valid` low, it checks that `out_sum` still holds the last valid value. Swaps are issued only after three idle cycles, so every sample in flight has already latched its products and each expectation uses exactly one profile.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

    localparam int unsigned DEF_SAMPLE_W = 14;
    localparam int unsigned DEF_COEF_W   = 16;
    localparam int unsigned DEF_LINE_LEN = 14;
    localparam int unsigned DEF_PATHS    = 9;

    // Width that holds the sum of n full-scale signed products exactly.
    function automatic int unsigned sum_width(int unsigned sw, int unsigned cw, int unsigned n);
        return sw + cw + $clog2(n);
    endfunction

endpackage

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned LINE_LEN = 14
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic [SAMPLE_W-1:0]                 in_sample,
    output logic [LINE_LEN-1:0][SAMPLE_W-1:0]   line,
    output logic                                line_valid
);

    typedef struct packed {
        logic [LINE_LEN-1:0][SAMPLE_W-1:0] cells;
        logic                              vld;
    } line_t;

    line_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.cells[0] = in_sample;
            for (int i = 1; i < int'(LINE_LEN); i++) begin
                state_d.cells[i] = state_q.cells[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign line       = state_q.cells;
    assign line_valid = state_q.vld;

endmodule

// File: rtl/sfir_tap_bank.sv
module sfir_tap_bank #(
    parameter int unsigned PATHS  = 9,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [IDX_W-1:0]                 cfg_delay,
    input  logic [COEF_W-1:0]                cfg_coef,
    input  logic                             cfg_swap,
    output logic [PATHS-1:0][IDX_W-1:0]      act_delay,
    output logic [PATHS-1:0][COEF_W-1:0]     act_coef
);

    typedef struct packed {
        logic [PATHS-1:0][IDX_W-1:0]  sh_dly;
        logic [PATHS-1:0][COEF_W-1:0] sh_coef;
        logic [PATHS-1:0][IDX_W-1:0]  ac_dly;
        logic [PATHS-1:0][COEF_W-1:0] ac_coef;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Swap takes the shadow contents from before any same-cycle write.
        if (cfg_swap) begin
            state_d.ac_dly  = state_q.sh_dly;
            state_d.ac_coef = state_q.sh_coef;
        end
        if (cfg_we) begin
            for (int k = 0; k < int'(PATHS); k++) begin
                if (cfg_sel == SEL_W'(k)) begin
                    state_d.sh_dly[k]  = cfg_delay;
                    state_d.sh_coef[k] = cfg_coef;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_delay = state_q.ac_dly;
    assign act_coef  = state_q.ac_coef;

endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned COEF_W   = 16,
    parameter int unsigned LINE_LEN = 14,
    parameter int unsigned PATHS    = 9,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned ACC_W    = 34
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [LINE_LEN-1:0][SAMPLE_W-1:0] line,
    input  logic                              line_valid,
    input  logic [PATHS-1:0][IDX_W-1:0]       act_delay,
    input  logic [PATHS-1:0][COEF_W-1:0]      act_coef,
    output logic [ACC_W-1:0]                  sum,
    output logic                              sum_valid
);

    localparam int unsigned PROD_W = SAMPLE_W + COEF_W;

    logic [PATHS-1:0][PROD_W-1:0] prod_w;

    for (genvar k = 0; k < int'(PATHS); k++) begin : g_path
        logic [SAMPLE_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int p = 0; p < int'(LINE_LEN); p++) begin
                if (act_delay[k] == IDX_W'(p)) begin
                    pick = line[p];
                end
            end
        end
        assign prod_w[k] = PROD_W'($signed(pick) * $signed(act_coef[k]));
    end

    typedef struct packed {
        logic [PATHS-1:0][PROD_W-1:0] prods;
        logic                         pv;
        logic [ACC_W-1:0]             acc;
        logic                         av;
    } mac_t;

    mac_t state_d, state_q;

    always_comb begin
        logic [ACC_W-1:0] total;
        state_d = state_q;
        state_d.pv = line_valid;
        if (line_valid) begin
            state_d.prods = prod_w;
        end
        total = '0;
        for (int k = 0; k < int'(PATHS); k++) begin
            total = total + {{(ACC_W-PROD_W){state_q.prods[k][PROD_W-1]}}, state_q.prods[k]};
        end
        state_d.av = state_q.pv;
        if (state_q.pv) begin
            state_d.acc = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum       = state_q.acc;
    assign sum_valid = state_q.av;

endmodule

// File: rtl/sparse_fir_channel.sv
module sparse_fir_channel
    import sfir_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned COEF_W   = DEF_COEF_W,
    parameter int unsigned LINE_LEN = DEF_LINE_LEN,
    parameter int unsigned PATHS    = DEF_PATHS,
    localparam int unsigned IDX_W   = $clog2(LINE_LEN + 1),
    localparam int unsigned SEL_W   = $clog2(PATHS + 1),
    localparam int unsigned ACC_W   = sum_width(SAMPLE_W, COEF_W, PATHS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [IDX_W-1:0]    cfg_delay,
    input  logic [COEF_W-1:0]   cfg_coef,
    input  logic                cfg_swap,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_sum
);

    logic [LINE_LEN-1:0][SAMPLE_W-1:0] line;
    logic                              line_valid;
    logic [PATHS-1:0][IDX_W-1:0]       act_delay;
    logic [PATHS-1:0][COEF_W-1:0]      act_coef;

    sfir_delay_line #(
        .SAMPLE_W (SAMPLE_W),
        .LINE_LEN (LINE_LEN)
    ) u_line (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .line       (line),
        .line_valid (line_valid)
    );

    sfir_tap_bank #(
        .PATHS  (PATHS),
        .IDX_W  (IDX_W),
        .COEF_W (COEF_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_delay (cfg_delay),
        .cfg_coef  (cfg_coef),
        .cfg_swap  (cfg_swap),
        .act_delay (act_delay),
        .act_coef  (act_coef)
    );

    sfir_mac #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .LINE_LEN (LINE_LEN),
        .PATHS    (PATHS),
        .IDX_W    (IDX_W),
        .ACC_W    (ACC_W)
    ) u_mac (
        .clk        (clk),
        .rst        (rst),
        .line       (line),
        .line_valid (line_valid),
        .act_delay  (act_delay),
        .act_coef   (act_coef),
        .sum        (out_sum),
        .sum_valid  (out_valid)
    );

endmodule

// File: rtl/sfir_checker.sv
module sfir_checker #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned COEF_W   = 16,
    parameter int unsigned PATHS    = 9,
    parameter int unsigned ACC_W    = 34
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_sum
);

    localparam logic signed [ACC_W-1:0] FULL_MAG =
        ACC_W'(PATHS) << (SAMPLE_W + COEF_W - 2);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: outputs are cleared by reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sum == '0));

    // R2: one strobe out, three edges after each accepted sample
    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3: the full-precision sum stays within the bound of all-full-scale products
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_sum) <= FULL_MAG && $signed(out_sum) >= -FULL_MAG));

    // R9: output held between strobes
    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |-> $stable(out_sum));

endmodule

bind sparse_fir_channel sfir_checker #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .PATHS    (PATHS),
    .ACC_W    (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/sim_sparse_fir_channel.sv
module sim_sparse_fir_channel;

    localparam int SW = 14;
    localparam int CW = 16;
    localparam int LL = 14;
    localparam int NP = 9;
    localparam int IW = 4;
    localparam int SLW = 4;
    localparam int AW = 34;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic          cfg_we = 1'b0;
    logic [SLW-1:0] cfg_sel = '0;
    logic [IW-1:0] cfg_delay = '0;
    logic [CW-1:0] cfg_coef = '0;
    logic          cfg_swap = 1'b0;
    logic          out_valid;
    logic [AW-1:0] out_sum;

    sparse_fir_channel u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_delay(cfg_delay),
        .cfg_coef(cfg_coef), .cfg_swap(cfg_swap),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // bench model
    int     sh_dly[NP];
    int     sh_coef[NP];
    int     ac_dly[NP];
    int     ac_coef[NP];
    longint hist[LL];
    longint exp_val[4096];
    string  exp_tag[4096];
    int     wr_ix = 0;
    int     rd_ix = 0;
    longint last_out = 0;
    logic [2:0] vh = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic longint model_sum();
        longint s = 0;
        for (int k = 0; k < NP; k++) begin
            if (ac_dly[k] < LL) s += longint'(ac_coef[k]) * hist[ac_dly[k]];
        end
        return s;
    endfunction

    task automatic drive(input bit v, input int x, input string tag);
        @(posedge clk); #1;
        in_valid  = v;
        in_sample = SW'(x);
        if (v) begin
            for (int i = LL - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = longint'(x);
            exp_val[wr_ix] = model_sum();
            exp_tag[wr_ix] = tag;
            wr_ix++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, "");
    endtask

    task automatic write_path(input int sel, input int dly, input int coef);
        @(posedge clk); #1;
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_sel   = SLW'(sel);
        cfg_delay = IW'(dly);
        cfg_coef  = CW'(coef);
        if (sel < NP) begin
            sh_dly[sel]  = dly;
            sh_coef[sel] = coef;
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic swap_bank();
        idle(3);
        @(posedge clk); #1;
        in_valid = 1'b0;
        cfg_swap = 1'b1;
        for (int k = 0; k < NP; k++) begin
            ac_dly[k]  = sh_dly[k];
            ac_coef[k] = sh_coef[k];
        end
        @(posedge clk); #1;
        cfg_swap = 1'b0;
    endtask

    // monitor away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            chk(out_valid == vh[2], "R2 strobe timing", longint'(out_valid), longint'(vh[2]));
            if (out_valid) begin
                if (rd_ix < wr_ix) begin
                    chk(longint'($signed(out_sum)) == exp_val[rd_ix], exp_tag[rd_ix],
                        longint'($signed(out_sum)), exp_val[rd_ix]);
                    rd_ix++;
                end else begin
                    chk(1'b0, "R2 extra strobe", 1, 0);
                end
                last_out = longint'($signed(out_sum));
            end else begin
                chk(longint'($signed(out_sum)) == last_out, "R9 hold",
                    longint'($signed(out_sum)), last_out);
            end
            vh = {vh[1:0], in_valid};
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int k = 0; k < NP; k++) begin
            sh_dly[k] = 0; sh_coef[k] = 0; ac_dly[k] = 0; ac_coef[k] = 0;
        end
        for (int i = 0; i < LL; i++) hist[i] = 0;

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
        chk(out_sum == '0, "R1 sum after reset", longint'($signed(out_sum)), 0);
        started = 1'b1;

        // R1: reset profile is all zero, so outputs are zero
        for (int i = 0; i < 4; i++) drive(1'b1, 100 + i, "R1 zero profile");
        idle(4);

        // R4: delay 0 path plus a delayed path, back-to-back samples
        write_path(0, 0, 3);
        write_path(1, 5, -2);
        swap_bank();
        for (int i = 0; i < 20; i++) drive(1'b1, i * 37 - 300, "R4 delay zero");
        idle(4);

        // R10: gaps between samples do not advance the line
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, 500 - i * 91, "R10 gapped input");
            idle(i % 3 + 1);
        end
        idle(4);

        // R5: shadow writes invisible before swap
        write_path(0, 2, 100);
        write_path(1, 7, 55);
        for (int i = 0; i < 10; i++) drive(1'b1, i * 13, "R5 shadow only");
        // R6: swap brings in the whole new set
        swap_bank();
        for (int i = 0; i < 10; i++) drive(1'b1, 40 - i * 7, "R6 after swap");
        idle(4);

        // R7: out-of-range delays contribute nothing
        write_path(2, 15, 1000);
        write_path(3, 14, 500);
        swap_bank();
        for (int i = 0; i < 16; i++) drive(1'b1, 8191 - i, "R7 delay out of range");
        idle(4);

        // R8: writes to non-existent paths ignored
        for (int s = NP; s < 16; s++) write_path(s, 1, 7777);
        swap_bank();
        for (int i = 0; i < 16; i++) drive(1'b1, -4000 + i * 3, "R8 bad path select");
        idle(4);

        // R3: full-scale, all paths, both signs of the product
        for (int k = 0; k < NP; k++) write_path(k, k, -32768);
        swap_bank();
        for (int i = 0; i < 16; i++) drive(1'b1, -8192, "R3 full scale positive");
        for (int k = 0; k < NP; k++) write_path(k, k, 32767);
        swap_bank();
        for (int i = 0; i < 16; i++) drive(1'b1, -8192, "R3 full scale negative");
        idle(4);

        // R3: random profiles and random streams
        for (int r = 0; r < 30; r++) begin
            for (int k = 0; k < NP; k++) begin
                int d;
                d = ($urandom_range(9) == 0) ? int'($urandom_range(15, 14)) : int'($urandom_range(13));
                write_path(k, d, int'($urandom_range(65535)) - 32768);
            end
            swap_bank();
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(9) < 7) drive(1'b1, int'($urandom_range(16383)) - 8192, "R3 random");
                else drive(1'b0, 0, "");
            end
            idle(2);
        end

        idle(8);
        chk(rd_ix == wr_ix, "R2 all samples produced", longint'(rd_ix), longint'(wr_ix));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule